// File: doc/BRIEF.md
# Set-Associative Tag Directory with Recent-Bit Replacement

This block keeps the tag directory of a set-associative cache on the memory side. Each set holds one entry per way. An entry carries a valid flag, a coherent flag, a counter-mode flag, a dirty flag, a lock flag, the tag, a copy count, the identity of one owner (a source id and an instruction flag) and a pointer into a sharer list. The data array and the sharer list are kept elsewhere. The coherence protocol that decides what gets written is also outside this block.

A main request port takes one operation per cycle. The operations are a lookup by line address that updates replacement state, a write of a whole entry at a given set and way, an invalidate at a given set and way, and victim selection for a set. A second port makes a neutral lookup that never touches replacement state.

Each way owns one recent bit. Writing an entry, or a lookup hit, sets the bit of that way. When the update would leave every way of the set recent, the bits of that set are wiped to zero instead. Both ports answer one clock after the request. Reset brings every entry and every recent bit to zero.

Top module: `setdir_top`

## Requirements
- R1: After reset no response is valid on either port. Every lookup misses, and victim selection on any set returns way 0 with an all-zero entry.
- R2: A lookup (req_op = 1) answers in the next cycle with rsp_valid. It reports a hit when an entry of the addressed set has a matching tag and its valid bit set. When several ways hit, the lowest-numbered one is reported, with its way, its set and its full entry.
- R3: A lookup whose tag matches only entries with a clear valid bit, or matches nothing, reports a miss with rsp_way 0 and an all-zero rsp_entry.
- R4: A write (req_op = 2) stores req_entry at req_set/req_way. Unless the wipe of R5 applies, it sets only the recent bit of the written way.
- R5: When a write or a lookup hit would mark a way while every other way of that set is already recent, all recent bits of the set become zero.
- R6: A lookup hit applies the recent-bit update of R4 and R5 to the hitting way.
- R7: A neutral lookup leaves every recent bit unchanged.
- R8: A neutral lookup (nl_valid) answers in the next cycle with nl_rsp_valid. On a hit it returns the set, the way and the entry, following the hit rule of R2. On a miss nl_hit is 0 and nl_way, nl_set and nl_entry are all zero.
- R9: An invalidate (req_op = 3) clears only the valid bit of the entry at req_set/req_way. Its other fields and the other entries are kept.
- R10: Victim selection (req_op = 4) returns in rsp_way the lowest-numbered invalid way of req_set. If no way is invalid, it returns the lowest-numbered way whose recent bit is clear, and way 0 if every recent bit is set. rsp_entry is the entry currently held at that way, and rsp_hit is 0.
- R11: When a write and a neutral lookup of the same set arrive in the same cycle, the neutral lookup sees the newly written entry.
- R12: Line-address fields are as follows. Bits [5:0] select the byte within the line and are ignored. Bits [9:6] are the set index. Bits [31:10] are the tag. The entry layout, from bit 51 down, is: valid[51], coherent[50], counter-mode[49], dirty[48], lock[47], tag[46:25], count[24:17], source id[16:9], instruction flag[8], pointer[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all entries and recent bits |
| req_valid | input | 1 | Main port request strobe |
| req_op | input | 3 | 1 lookup, 2 write, 3 invalidate, 4 victim select; other codes do nothing |
| req_addr | input | 32 | Line address for a lookup |
| req_set | input | 4 | Set for write, invalidate and select |
| req_way | input | 2 | Way for write and invalidate |
| req_entry | input | 52 | Entry to store on a write |
| rsp_valid | output | 1 | Main port response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Hit way or victim way |
| rsp_set | output | 4 | Set of the response |
| rsp_entry | output | 52 | Entry of the hit or victim way |
| nl_valid | input | 1 | Neutral lookup strobe |
| nl_addr | input | 32 | Neutral lookup line address |
| nl_rsp_valid | output | 1 | Neutral response valid |
| nl_hit | output | 1 | Neutral lookup hit |
| nl_way | output | 2 | Neutral hit way |
| nl_set | output | 4 | Neutral hit set |
| nl_entry | output | 52 | Neutral hit entry |

## Verification
The recent bits cannot be read directly. They show only through the victim choice, and only once every way of a set is valid. The hardest case is the wipe to zero, which only happens on the update that would complete the set. The stimulus fills one set way by way and then calls victim selection after each write, lookup hit and neutral lookup. This reveals each step of the bit pattern, including the wipe caused by a write and the wipe caused by a lookup. A write and a neutral lookup to the same set in the same cycle exercise the write-first ordering.

// File: rtl/setdir_pkg.sv
package setdir_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LOOKUP = 3'd1,
        OP_WRITE  = 3'd2,
        OP_INVAL  = 3'd3,
        OP_SELECT = 3'd4
    } dir_op_e;

endpackage

// File: rtl/setdir_match.sv
module setdir_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    parameter int WAY_B = 2
) (
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]       way_valid,
    input  logic [TAG_W-1:0]      tag,
    output logic                  hit,
    output logic [WAY_B-1:0]      way
);
    logic [WAYS-1:0] hv;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hv[g] = way_valid[g] && (way_tags[g*TAG_W +: TAG_W] == tag);
    end

    always_comb begin
        way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hv[i]) way = WAY_B'(i);
        end
    end

    assign hit = |hv;
endmodule

// File: rtl/setdir_victim.sv
module setdir_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_B = 2
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAYS-1:0]  recent,
    output logic [WAY_B-1:0] victim
);
    always_comb begin
        victim = '0;
        if (!(&way_valid)) begin
            for (int i = WAYS - 1; i >= 0; i--) begin
                if (!way_valid[i]) victim = WAY_B'(i);
            end
        end else begin
            for (int i = WAYS - 1; i >= 0; i--) begin
                if (!recent[i]) victim = WAY_B'(i);
            end
        end
    end
endmodule

// File: rtl/setdir_recent.sv
module setdir_recent #(
    parameter int WAYS  = 4,
    parameter int WAY_B = 2
) (
    input  logic [WAYS-1:0]  cur,
    input  logic [WAY_B-1:0] way,
    output logic [WAYS-1:0]  nxt
);
    logic [WAYS-1:0] marked;

    assign marked = cur | (WAYS'(1) << way);
    assign nxt    = (&marked) ? '0 : marked;
endmodule

// File: rtl/setdir_top.sv
module setdir_top
    import setdir_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int WORDS  = 16,
    parameter int CNT_W  = 8,
    parameter int SRC_W  = 8,
    parameter int PTR_W  = 8,
    localparam int WAY_B  = $clog2(WAYS),
    localparam int SET_B  = $clog2(SETS),
    localparam int OFF_B  = $clog2(WORDS) + 2,
    localparam int TAG_W  = ADDR_W - SET_B - OFF_B,
    localparam int TAG_LO = CNT_W + SRC_W + 1 + PTR_W,
    localparam int ENT_W  = 5 + TAG_W + TAG_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SET_B-1:0]  req_set,
    input  logic [WAY_B-1:0]  req_way,
    input  logic [ENT_W-1:0]  req_entry,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_B-1:0]  rsp_way,
    output logic [SET_B-1:0]  rsp_set,
    output logic [ENT_W-1:0]  rsp_entry,
    input  logic              nl_valid,
    input  logic [ADDR_W-1:0] nl_addr,
    output logic              nl_rsp_valid,
    output logic              nl_hit,
    output logic [WAY_B-1:0]  nl_way,
    output logic [SET_B-1:0]  nl_set,
    output logic [ENT_W-1:0]  nl_entry
);
    localparam int VLD_POS = ENT_W - 1;

    logic [ENT_W-1:0] ent_q [SETS][WAYS];
    logic [ENT_W-1:0] ent_n [SETS][WAYS];
    logic [WAYS-1:0]  rec_q [SETS];
    logic [WAYS-1:0]  rec_n [SETS];

    dir_op_e          op;
    logic [SET_B-1:0] a_set, n_set, upd_set;
    logic [TAG_W-1:0] a_tag, n_tag;
    logic [WAYS*TAG_W-1:0] a_tags, n_tags;
    logic [WAYS-1:0]  a_vld, n_vld, s_vld, rec_upd;
    logic             a_hit, n_hit;
    logic [WAY_B-1:0] a_way, n_way, vic, upd_way;
    logic             unused_offs;

    assign op          = dir_op_e'(req_op);
    assign a_set       = req_addr[OFF_B +: SET_B];
    assign a_tag       = req_addr[OFF_B + SET_B +: TAG_W];
    assign n_set       = nl_addr[OFF_B +: SET_B];
    assign n_tag       = nl_addr[OFF_B + SET_B +: TAG_W];
    assign unused_offs = ^{req_addr[OFF_B-1:0], nl_addr[OFF_B-1:0]};

    // Per-way views of the addressed sets; the neutral view is post-write.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            a_tags[w*TAG_W +: TAG_W] = ent_q[a_set][w][TAG_LO +: TAG_W];
            a_vld[w]                 = ent_q[a_set][w][VLD_POS];
            n_tags[w*TAG_W +: TAG_W] = ent_n[n_set][w][TAG_LO +: TAG_W];
            n_vld[w]                 = ent_n[n_set][w][VLD_POS];
            s_vld[w]                 = ent_q[req_set][w][VLD_POS];
        end
    end

    setdir_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_B(WAY_B)) u_match_main (
        .way_tags(a_tags), .way_valid(a_vld), .tag(a_tag), .hit(a_hit), .way(a_way)
    );

    setdir_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_B(WAY_B)) u_match_neutral (
        .way_tags(n_tags), .way_valid(n_vld), .tag(n_tag), .hit(n_hit), .way(n_way)
    );

    setdir_victim #(.WAYS(WAYS), .WAY_B(WAY_B)) u_victim (
        .way_valid(s_vld), .recent(rec_q[req_set]), .victim(vic)
    );

    assign upd_set = (op == OP_WRITE) ? req_set : a_set;
    assign upd_way = (op == OP_WRITE) ? req_way : a_way;

    setdir_recent #(.WAYS(WAYS), .WAY_B(WAY_B)) u_recent (
        .cur(rec_q[upd_set]), .way(upd_way), .nxt(rec_upd)
    );

    // Next directory and replacement state.
    always_comb begin
        ent_n = ent_q;
        rec_n = rec_q;
        if (req_valid) begin
            unique case (op)
                OP_WRITE: begin
                    ent_n[req_set][req_way] = req_entry;
                    rec_n[req_set]          = rec_upd;
                end
                OP_INVAL:  ent_n[req_set][req_way][VLD_POS] = 1'b0;
                OP_LOOKUP: if (a_hit) rec_n[a_set] = rec_upd;
                default: ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rec_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) ent_q[s][w] <= '0;
            end
        end else begin
            ent_q <= ent_n;
            rec_q <= rec_n;
        end
    end

    // Registered responses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_way      <= '0;
            rsp_set      <= '0;
            rsp_entry    <= '0;
            nl_rsp_valid <= 1'b0;
            nl_hit       <= 1'b0;
            nl_way       <= '0;
            nl_set       <= '0;
            nl_entry     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (req_valid) begin
                unique case (op)
                    OP_LOOKUP: begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= a_hit;
                        rsp_way   <= a_hit ? a_way : '0;
                        rsp_set   <= a_set;
                        rsp_entry <= a_hit ? ent_q[a_set][a_way] : '0;
                    end
                    OP_SELECT: begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_way   <= vic;
                        rsp_set   <= req_set;
                        rsp_entry <= ent_q[req_set][vic];
                    end
                    default: ;
                endcase
            end
            nl_rsp_valid <= nl_valid;
            if (nl_valid) begin
                nl_hit   <= n_hit;
                nl_way   <= n_hit ? n_way : '0;
                nl_set   <= n_hit ? n_set : '0;
                nl_entry <= n_hit ? ent_n[n_set][n_way] : '0;
            end
        end
    end
endmodule

// File: rtl/setdir_chk.sv
module setdir_chk #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 22,
    parameter int SET_B  = 4,
    parameter int OFF_B  = 6,
    parameter int ENT_W  = 52,
    parameter int TAG_LO = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [ENT_W-1:0]  rsp_entry,
    input logic              nl_valid,
    input logic [ADDR_W-1:0] nl_addr,
    input logic              nl_rsp_valid,
    input logic              nl_hit,
    input logic [ENT_W-1:0]  nl_entry
);
    logic asks;
    assign asks = req_valid && (req_op == 3'd1 || req_op == 3'd4);

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asks |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !asks |=> !rsp_valid);

    // R2
    hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> rsp_entry[ENT_W-1]);

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit && $past(req_op) == 3'd1 |-> rsp_entry == '0);

    // R8
    nl_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nl_valid |=> nl_rsp_valid);

    // R8
    nl_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nl_rsp_valid && nl_hit |->
            nl_entry[TAG_LO +: TAG_W] == $past(nl_addr[OFF_B + SET_B +: TAG_W]));

    // R8
    nl_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nl_rsp_valid && !nl_hit |-> nl_entry == '0);
endmodule

bind setdir_top setdir_chk #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .SET_B(SET_B),
    .OFF_B(OFF_B), .ENT_W(ENT_W), .TAG_LO(TAG_LO)
) u_setdir_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_entry(rsp_entry),
    .nl_valid(nl_valid), .nl_addr(nl_addr), .nl_rsp_valid(nl_rsp_valid),
    .nl_hit(nl_hit), .nl_entry(nl_entry)
);

// File: tb/setdir_top_bench.sv
`timescale 1ns/1ps
module setdir_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_set = '0;
    logic [1:0]  req_way = '0;
    logic [51:0] req_entry = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_way;
    logic [3:0]  rsp_set;
    logic [51:0] rsp_entry;
    logic        nl_valid = 1'b0;
    logic [31:0] nl_addr = '0;
    logic        nl_rsp_valid, nl_hit;
    logic [1:0]  nl_way;
    logic [3:0]  nl_set;
    logic [51:0] nl_entry;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    setdir_top u_setdir_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_set(req_set), .req_way(req_way),
        .req_entry(req_entry), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_way(rsp_way), .rsp_set(rsp_set), .rsp_entry(rsp_entry),
        .nl_valid(nl_valid), .nl_addr(nl_addr), .nl_rsp_valid(nl_rsp_valid),
        .nl_hit(nl_hit), .nl_way(nl_way), .nl_set(nl_set), .nl_entry(nl_entry)
    );

    function automatic logic [51:0] mk(input bit v, input logic [21:0] tag, input logic [7:0] ptr);
        return {v, 1'b1, 1'b0, 1'b1, 1'b0, tag, 8'd3, 8'h5A, 1'b1, ptr};
    endfunction

    function automatic logic [31:0] adr(input logic [21:0] tag, input logic [3:0] s);
        return {tag, s, 6'b0};
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One request cycle; outputs are sampled at the following falling edge.
    task automatic cyc(input logic [2:0] op, input logic [31:0] a, input logic [3:0] s,
                       input logic [1:0] w, input logic [51:0] e,
                       input bit nv, input logic [31:0] na);
        @(negedge clk);
        req_valid = (op != 3'd0); req_op = op; req_addr = a;
        req_set = s; req_way = w; req_entry = e;
        nl_valid = nv; nl_addr = na;
        @(negedge clk);
        req_valid = 1'b0; nl_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] s, input logic [1:0] w, input logic [51:0] e);
        cyc(3'd2, '0, s, w, e, 1'b0, '0);
    endtask

    task automatic look(input logic [31:0] a);
        cyc(3'd1, a, '0, '0, '0, 1'b0, '0);
    endtask

    task automatic sel(input logic [3:0] s);
        cyc(3'd4, '0, s, '0, '0, 1'b0, '0);
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid idle", rsp_valid, 0);
        chk("R1 nl_rsp_valid idle", nl_rsp_valid, 0);
        look(adr(22'h0, 4'd0));
        chk("R1 lookup valid", rsp_valid, 1);
        chk("R1 R3 lookup miss", rsp_hit, 0);
        chk("R3 miss entry", rsp_entry, 0);
        sel(4'd3);
        chk("R1 R10 select way", rsp_way, 0);
        chk("R1 select entry", rsp_entry, 0);
    endtask

    task automatic t_write_lookup;
        wr(4'd5, 2'd2, mk(1, 22'h1234, 8'h11));
        look(adr(22'h1234, 4'd5) | 32'h3C);
        chk("R2 R12 hit", rsp_hit, 1);
        chk("R2 way", rsp_way, 2);
        chk("R2 set", rsp_set, 5);
        chk("R4 R2 entry", rsp_entry, mk(1, 22'h1234, 8'h11));
        look(adr(22'h1234, 4'd6));
        chk("R12 other set misses", rsp_hit, 0);
    endtask

    task automatic t_lowest_and_invalid;
        wr(4'd7, 2'd3, mk(1, 22'h77, 8'h33));
        wr(4'd7, 2'd1, mk(1, 22'h77, 8'h31));
        look(adr(22'h77, 4'd7));
        chk("R2 lowest way", rsp_way, 1);
        chk("R2 lowest entry", rsp_entry, mk(1, 22'h77, 8'h31));
        wr(4'd8, 2'd0, mk(0, 22'h88, 8'h01));
        look(adr(22'h88, 4'd8));
        chk("R3 invalid tag miss", rsp_hit, 0);
        chk("R3 invalid entry zero", rsp_entry, 0);
    endtask

    task automatic t_recent;
        for (int w = 0; w < 3; w++) wr(4'd9, 2'(w), mk(1, 22'h100 + 22'(w), 8'(w)));
        sel(4'd9);
        chk("R10 lowest invalid way", rsp_way, 3);
        wr(4'd9, 2'd3, mk(1, 22'h103, 8'd3));
        sel(4'd9);
        chk("R5 write wipe", rsp_way, 0);
        wr(4'd9, 2'd0, mk(1, 22'h100, 8'd0));
        sel(4'd9);
        chk("R4 recent mark", rsp_way, 1);
        look(adr(22'h101, 4'd9));
        chk("R6 hit way", rsp_way, 1);
        sel(4'd9);
        chk("R6 lookup marks", rsp_way, 2);
        cyc(3'd0, '0, '0, '0, '0, 1'b1, adr(22'h102, 4'd9));
        chk("R8 neutral hit", nl_hit, 1);
        chk("R8 neutral way", nl_way, 2);
        chk("R8 neutral set", nl_set, 9);
        chk("R8 neutral entry", nl_entry, mk(1, 22'h102, 8'd2));
        sel(4'd9);
        chk("R7 neutral keeps recent", rsp_way, 2);
        look(adr(22'h102, 4'd9));
        look(adr(22'h103, 4'd9));
        sel(4'd9);
        chk("R5 lookup wipe", rsp_way, 0);
    endtask

    task automatic t_inval;
        cyc(3'd3, '0, 4'd9, 2'd2, '0, 1'b0, '0);
        sel(4'd9);
        chk("R9 R10 invalid preferred", rsp_way, 2);
        chk("R9 fields kept", rsp_entry, mk(0, 22'h102, 8'd2));
        look(adr(22'h102, 4'd9));
        chk("R9 lookup misses", rsp_hit, 0);
        look(adr(22'h101, 4'd9));
        chk("R9 neighbour intact", rsp_hit, 1);
    endtask

    task automatic t_neutral_miss;
        cyc(3'd0, '0, '0, '0, '0, 1'b1, adr(22'h3FF, 4'd2));
        chk("R8 neutral miss", nl_hit, 0);
        chk("R8 miss entry", nl_entry, 0);
        chk("R8 miss way", nl_way, 0);
        chk("R8 miss set", nl_set, 0);
    endtask

    task automatic t_write_first;
        cyc(3'd2, '0, 4'd10, 2'd1, mk(1, 22'h2AA, 8'h07), 1'b1, adr(22'h2AA, 4'd10));
        chk("R11 sees write", nl_hit, 1);
        chk("R11 way", nl_way, 1);
        chk("R11 entry", nl_entry, mk(1, 22'h2AA, 8'h07));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_lookup();
        t_lowest_and_invalid();
        t_recent();
        t_inval();
        t_neutral_miss();
        t_write_first();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule